// File: doc/BRIEF.md
# Threshold Alert and Conversion-Ready Pin Logic

This block drives the single alert output of an analog-to-digital converter. It holds a signed low threshold and a signed high threshold, and each time the converter reports a finished result it compares that result against both. The pin goes low when a result reaches the high threshold. It goes high again only when a later result drops below the low threshold, so results that fall between the two thresholds leave the pin where it is.

Software can also turn the pin into a conversion-ready indicator by writing a particular pattern into the two top bits of the thresholds: the high threshold's top bit set and the low threshold's top bit clear. In that setting the pin behaves according to the conversion mode. In single-shot operation it mirrors the converter's operational-status bit. In continuous operation it gives a one-cycle low pulse for each finished conversion.

The thresholds are written through a simple select, data and strobe port, and the selected register can be read back at any time.

Top module: `adc_alert_top`

## Requirements
- R1: A write with `wrEn` high stores `wrData` into the low threshold when `regSel`=0 and into the high threshold when `regSel`=1, at that clock edge. `rdData` always shows the current contents of the register chosen by `regSel`. Without a write, both registers keep their values.
- R2: During and after reset, the low threshold reads 16'h8000 and the high threshold reads 16'h7FFF.
- R3: Ready mode is selected whenever bit 15 of the high threshold is 1 and bit 15 of the low threshold is 0. Every other combination selects comparator mode.
- R4: In ready mode with `contMode`=0, `alertN` equals the value `opStatus` had in the previous cycle.
- R5: In ready mode with `contMode`=1, `alertN` is low for exactly the one cycle after a cycle with `convDone` high, and high otherwise.
- R6: In comparator mode, a cycle with `convDone` high and `convResult` >= the high threshold (signed) drives `alertN` low in the next cycle. This condition takes priority over R7 when the thresholds are inverted.
- R7: In comparator mode, a cycle with `convDone` high and `convResult` < the low threshold (signed), and not covered by R6, drives `alertN` high in the next cycle.
- R8: In comparator mode, a finished result between the thresholds leaves `alertN` unchanged, and so does a cycle without `convDone`.
- R9: `alertN` is high during reset and in the first cycle after it.
- R10: A threshold write that changes the mode takes effect on the pin from the cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 = low threshold, 1 = high threshold |
| wrData | input | 16 | Write data |
| wrEn | input | 1 | Write strobe |
| rdData | output | 16 | Contents of the selected threshold |
| convResult | input | 16 | Signed conversion result |
| convDone | input | 1 | One-cycle strobe marking a finished conversion |
| contMode | input | 1 | 1 = continuous conversion, 0 = single-shot |
| opStatus | input | 1 | Converter operational-status bit |
| alertN | output | 1 | Active-low alert / ready pin |

## Verification
Every pin result is due one clock edge after the inputs that cause it. A register write is visible on `rdData` after that same edge. The bench drives each stimulus just after a falling edge and waits through one rising edge. It then samples both `alertN` and `rdData` at the next falling edge, against a model that was advanced with the thresholds as they stood before the write. With this timing, a write that changes the mode is always judged under the old mode in its own cycle and under the new mode in the cycle after, which is exactly the boundary R10 describes.

// File: rtl/adc_alert_pkg.sv
package adc_alert_pkg;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
  } thrStrobe_t;

  typedef enum logic [1:0] {
    SRC_COMPARE   = 2'd0,
    SRC_RDY_SHOT  = 2'd1,
    SRC_RDY_CONT  = 2'd2
  } pinSrc_t;

endpackage

// File: rtl/thr_datapath.sv
module thr_datapath
  import adc_alert_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  thrStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              regSel,
  input  logic [DATA_W-1:0] convResult,
  output logic [DATA_W-1:0] rdData,
  output logic              aboveHi,
  output logic              belowLo,
  output logic              readyMode
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] LO_RESET = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] HI_RESET = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] loReg;
  logic [DATA_W-1:0] hiReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg <= LO_RESET;
      hiReg <= HI_RESET;
    end else begin
      if (strb.wrLo) loReg <= wrData;
      if (strb.wrHi) hiReg <= wrData;
    end
  end

  always_comb begin
    rdData    = regSel ? hiReg : loReg;
    aboveHi   = $signed(convResult) >= $signed(hiReg);
    belowLo   = $signed(convResult) <  $signed(loReg);
    readyMode = hiReg[MSB] & ~loReg[MSB];
  end

  p_lo_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLo |=> $stable(loReg));
  p_hi_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrHi |=> $stable(hiReg));
  p_hi_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> hiReg == $past(wrData));
  p_lo_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> loReg == $past(wrData));

endmodule

// File: rtl/thr_control.sv
module thr_control
  import adc_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regSel,
  input  logic       readyMode,
  input  logic       contMode,
  input  logic       opStatus,
  input  logic       convDone,
  input  logic       aboveHi,
  input  logic       belowLo,
  output thrStrobe_t strb,
  output logic       alertN
);

  pinSrc_t pinSrc;
  logic    tripped;
  logic    trippedNext;
  logic    pinNext;

  always_comb begin
    strb.wrLo = wrEn & ~regSel;
    strb.wrHi = wrEn &  regSel;
  end

  always_comb begin
    if (!readyMode)    pinSrc = SRC_COMPARE;
    else if (contMode) pinSrc = SRC_RDY_CONT;
    else               pinSrc = SRC_RDY_SHOT;
  end

  always_comb begin
    trippedNext = tripped;
    if (pinSrc == SRC_COMPARE && convDone) begin
      if (aboveHi)      trippedNext = 1'b1;
      else if (belowLo) trippedNext = 1'b0;
    end
    unique case (pinSrc)
      SRC_RDY_SHOT: pinNext = opStatus;
      SRC_RDY_CONT: pinNext = ~convDone;
      default:      pinNext = ~trippedNext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripped <= 1'b0;
      alertN  <= 1'b1;
    end else begin
      tripped <= trippedNext;
      alertN  <= pinNext;
    end
  end

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLo, strb.wrHi}));
  p_single_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    (readyMode && !contMode) |=> alertN == $past(opStatus));
  p_cont_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (readyMode && contMode && convDone) |=> !alertN);
  p_cont_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (readyMode && contMode && !convDone) |=> alertN);
  p_trip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!readyMode && convDone && aboveHi) |=> !alertN);
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!readyMode && convDone && belowLo && !aboveHi) |=> alertN);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!readyMode && $past(!readyMode) && (!convDone || (!aboveHi && !belowLo)))
      |=> $stable(alertN));

endmodule

// File: rtl/adc_alert_top.sv
module adc_alert_top
  import adc_alert_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] convResult,
  input  logic              convDone,
  input  logic              contMode,
  input  logic              opStatus,
  output logic              alertN
);

  thrStrobe_t strb;
  logic       aboveHi;
  logic       belowLo;
  logic       readyMode;

  thr_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .regSel     (regSel),
    .convResult (convResult),
    .rdData     (rdData),
    .aboveHi    (aboveHi),
    .belowLo    (belowLo),
    .readyMode  (readyMode)
  );

  thr_control i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .regSel    (regSel),
    .readyMode (readyMode),
    .contMode  (contMode),
    .opStatus  (opStatus),
    .convDone  (convDone),
    .aboveHi   (aboveHi),
    .belowLo   (belowLo),
    .strb      (strb),
    .alertN    (alertN)
  );

  p_reset_pin_r9: assert property (@(posedge clk)
    !rstN |=> alertN);

endmodule

// File: tb/test_adc_alert_top.sv
`timescale 1ns/1ps
module test_adc_alert_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regSel;
  logic [15:0] wrData;
  logic        wrEn;
  logic [15:0] rdData;
  logic [15:0] convResult;
  logic        convDone;
  logic        contMode;
  logic        opStatus;
  logic        alertN;

  int total = 0;
  int bad   = 0;

  logic [15:0] loM;
  logic [15:0] hiM;
  logic        tripM;

  always #2 clk = ~clk;

  adc_alert_top i_adc_alert_top (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .convResult(convResult), .convDone(convDone),
    .contMode(contMode), .opStatus(opStatus), .alertN(alertN)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic isReady(input logic [15:0] lo, input logic [15:0] hi);
    return hi[15] & ~lo[15];   // R3 decode
  endfunction

  task automatic step(input logic sel, input logic [15:0] d, input logic we,
                      input logic [15:0] res, input logic done,
                      input logic cont, input logic os);
    logic  expPin;
    string tag;
    regSel = sel; wrData = d; wrEn = we; convResult = res;
    convDone = done; contMode = cont; opStatus = os;
    if (isReady(loM, hiM)) begin
      if (cont) begin expPin = ~done; tag = "R5"; end
      else      begin expPin = os;    tag = "R4"; end
    end else begin
      tag = "R8";
      if (done) begin
        if ($signed(res) >= $signed(hiM))     begin tripM = 1'b1; tag = "R6"; end
        else if ($signed(res) < $signed(loM)) begin tripM = 1'b0; tag = "R7"; end
      end
      expPin = ~tripM;
    end
    if (we) begin
      if (sel) hiM = d; else loM = d;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, {15'd0, alertN}, {15'd0, expPin});
    chk("R1", rdData, sel ? hiM : loM);
  endtask

  initial begin
    #(4.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; regSel = 1'b0; wrData = '0; wrEn = 1'b0; convResult = '0;
    convDone = 1'b0; contMode = 1'b0; opStatus = 1'b0;
    loM = 16'h8000; hiM = 16'h7FFF; tripM = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", {15'd0, alertN}, 16'd1);
    chk("R2", rdData, 16'h8000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", {15'd0, alertN}, 16'd1);
    regSel = 1'b1; #1;
    chk("R2", rdData, 16'h7FFF);

    // R6 boundary at the reset high threshold
    step(1'b0, 16'h0, 1'b0, 16'h7FFE, 1'b1, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 16'h7FFF, 1'b1, 1'b0, 1'b0);
    // R1 writes: lo = -256, hi = 256
    step(1'b0, 16'hFF00, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 16'h0100, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 16'hFEFF, 1'b1, 1'b0, 1'b0);  // R7 release
    step(1'b0, 16'h0, 1'b0, 16'h0100, 1'b1, 1'b0, 1'b0);  // R6 equal hi
    step(1'b0, 16'h0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);  // R8 hold
    step(1'b0, 16'h0, 1'b0, 16'hFF00, 1'b1, 1'b0, 1'b0);  // R8 equal lo holds
    step(1'b0, 16'h0, 1'b0, 16'hFEFF, 1'b1, 1'b0, 1'b0);  // R7
    step(1'b0, 16'h0, 1'b0, 16'h00FF, 1'b1, 1'b0, 1'b0);  // R8
    // R10 / R3: enter ready mode
    step(1'b0, 16'h0000, 1'b1, 16'h0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 16'h8000, 1'b1, 16'h7FFF, 1'b1, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);     // R4 low
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);     // R4 high
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b1, 1'b1);     // R5 pulse
    step(1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0);     // R5 idle
    step(1'b1, 16'h0100, 1'b1, 16'h0, 1'b1, 1'b1, 1'b0);  // R10 leave
    step(1'b0, 16'h0, 1'b0, 16'h0200, 1'b0, 1'b1, 1'b0);  // R8 no done

    for (int i = 0; i < 4000; i++) begin
      logic        sel, we, done, cont, os;
      logic [15:0] d, res;
      sel  = 1'($urandom);
      we   = ($urandom % 8) == 0;
      d    = ($urandom % 2) ? 16'($urandom) : 16'($signed(sel ? hiM : loM) + $signed(16'($urandom % 64)) - 16'sd32);
      done = ($urandom % 3) != 0;
      cont = ($urandom % 4) == 0;
      os   = 1'($urandom);
      case ($urandom % 4)
        0: res = 16'($urandom);
        1: res = hiM + 16'($urandom % 5) - 16'd2;
        2: res = loM + 16'($urandom % 5) - 16'd2;
        default: res = 16'($signed(loM) + ($signed(hiM) - $signed(loM)) / 2);
      endcase
      step(sel, d, we, res, done, cont, os);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule